// File: doc/BRIEF.md
# Bad Block Remap Table with Spare Pool

This block keeps the translation from logical block numbers to physical flash blocks, along with a small pool of reserved spare physical blocks. At reset every logical block maps to the physical block of the same number, and the spares sit above the logical range. When the surrounding controller finds that a physical block has failed, it sends a mark request naming that physical block. The table finds the logical entry that points at it, takes the next unused spare, points the entry at the spare, and writes a record of the failure.

Each record holds the logical and physical block involved, whether the failure was found at production test or during use, a detection time taken from a free-running counter, and a migration state. A failed block that still holds live data is recorded as migration pending until the controller reports, through a migrate-done input that carries the record index, that the data has moved. A block that was only about to be written is retired at once, so the write lands straight on the spare. Lookups return the current mapping, which never names a recorded bad block, and flag a logical block whose data is still waiting to be moved. Copying the data itself, saving the table to flash and wear leveling are left to other blocks.

Top module: `bbr_remap_table`

## Requirements
- R1: After reset, a lookup of any logical block l returns physical block l with the pending flag low, no record slot is valid, and `spare_exhausted` is low.
- R2: A mark request naming a physical block that some logical entry maps to takes the lowest unused spare (spare k is physical block NUM_LOG+k, used in ascending order); that logical entry then maps to the spare, and the record is written into slot k.
- R3: A record stores the logical block, the failed physical block, the type bit from the request (0 = found at production test, 1 = found in use) and the detection time, which is the value of a counter that starts at 0 when reset is released and steps by one on every clock edge, taken at the edge that accepts the mark.
- R4: A mark with the has-data bit set leaves the record in the pending state (`rec_pending` = 1) and lookups of that logical block report `rsp_pending` = 1; a migrate-done naming that slot retires the record and clears both flags, and a retired record never returns to pending.
- R5: A mark with the has-data bit clear writes the record already retired, and lookups of the logical block return the spare with `rsp_pending` = 0.
- R6: The lookup response appears one cycle after the request, carries the current mapping of the requested logical block, and never names a physical block held in a valid record.
- R7: A mark on a mapped block when all spares are used sets `spare_exhausted`, which stays set until reset, and changes neither the mapping nor the records.
- R8: A mark naming a physical block that no logical entry maps to (a block already recorded bad, or a spare not yet handed out) is ignored: no spare is used, no record written, `spare_exhausted` unchanged.
- R9: A migrate-done naming an unused slot or an already retired record has no effect.
- R10: A spare that has been handed out can itself be marked bad, and its logical block then moves on to the next unused spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_lblk | input | LW | Logical block to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_pblk | output | PW | Physical block for the requested logical block |
| rsp_pending | output | 1 | Data of this logical block still awaits migration |
| mk_valid | input | 1 | Mark-bad request strobe |
| mk_pblk | input | PW | Physical block found bad |
| mk_new | input | 1 | Type: 0 production-test failure, 1 failure in use |
| mk_has_data | input | 1 | Failed block holds live data |
| md_valid | input | 1 | Migration-done strobe |
| md_idx | input | SW | Record slot whose data has moved |
| rec_idx | input | SW | Record slot to read |
| rec_valid | output | 1 | Selected slot holds a record |
| rec_lblk | output | LW | Logical block of the record |
| rec_pblk | output | PW | Failed physical block |
| rec_new | output | 1 | Record type bit |
| rec_time | output | TS_W | Detection time |
| rec_pending | output | 1 | Record awaits migration |
| spare_exhausted | output | 1 | Sticky: a mark arrived with no spare left |

## Verification
On every cycle the checker watches that a lookup never returns a physical block held by a valid record, that a record's time equals the counter at the accepting edge, that retired records stay retired and only clear through a migrate-done for their own slot, that the exhausted flag is sticky, and that ignored or refused marks leave the mapping and the record set untouched. Only the bench scenarios show which spare is chosen and in what order, the stored type and logical fields, the pending flag seen through lookups, chained failure of a handed-out spare, and that a migrate-done on an empty slot does not pre-clear a record written later.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
   typedef enum logic {
      BK_FACTORY = 1'b0,
      BK_IN_USE  = 1'b1
   } bad_kind_e;

   typedef enum logic {
      MIG_RETIRED = 1'b0,
      MIG_PENDING = 1'b1
   } mig_state_e;
endpackage

// File: rtl/bbr_spare_pool.sv
module bbr_spare_pool #(
   parameter int NUM_LOG   = 16,
   parameter int NUM_SPARE = 4,
   localparam int PW = $clog2(NUM_LOG + NUM_SPARE),
   localparam int SW = $clog2(NUM_SPARE),
   localparam int CW = $clog2(NUM_SPARE + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   output logic          grant,
   output logic [SW-1:0] slot,
   output logic [PW-1:0] spare_pblk,
   output logic          exhausted
);
   logic [CW-1:0] used_q;
   logic          full;

   assign full       = (used_q == CW'(NUM_SPARE));
   assign grant      = take & ~full;
   assign slot       = used_q[SW-1:0];
   assign spare_pblk = PW'(NUM_LOG) + PW'(used_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q    <= '0;
         exhausted <= 1'b0;
      end else begin
         if (grant)
            used_q <= used_q + CW'(1);
         if (take && full)
            exhausted <= 1'b1;
      end
   end
endmodule

// File: rtl/bbr_map_table.sv
module bbr_map_table #(
   parameter int NUM_LOG   = 16,
   parameter int NUM_SPARE = 4,
   localparam int LW = $clog2(NUM_LOG),
   localparam int PW = $clog2(NUM_LOG + NUM_SPARE)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PW-1:0]               find_pblk,
   output logic                        hit,
   output logic [LW-1:0]               hit_lblk,
   input  logic                        wr_en,
   input  logic [LW-1:0]               wr_lblk,
   input  logic [PW-1:0]               wr_pblk,
   input  logic [LW-1:0]               rd_lblk,
   output logic [PW-1:0]               rd_pblk,
   output logic [NUM_LOG-1:0][PW-1:0]  map_flat
);
   logic [PW-1:0] map_q [NUM_LOG];

   for (genvar l = 0; l < NUM_LOG; l++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            map_q[l] <= PW'(l);
         else if (wr_en && (wr_lblk == LW'(l)))
            map_q[l] <= wr_pblk;
      end
      assign map_flat[l] = map_q[l];
   end

   // Entries are always distinct, so at most one matches.
   always_comb begin
      hit      = 1'b0;
      hit_lblk = '0;
      for (int l = 0; l < NUM_LOG; l++) begin
         if (map_q[l] == find_pblk) begin
            hit      = 1'b1;
            hit_lblk = LW'(l);
         end
      end
   end

   assign rd_pblk = map_q[rd_lblk];
endmodule

// File: rtl/bbr_record_file.sv
module bbr_record_file #(
   parameter int NUM_LOG   = 16,
   parameter int NUM_SPARE = 4,
   parameter int TS_W      = 16,
   localparam int LW = $clog2(NUM_LOG),
   localparam int PW = $clog2(NUM_LOG + NUM_SPARE),
   localparam int SW = $clog2(NUM_SPARE)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [SW-1:0]                 wr_slot,
   input  logic [LW-1:0]                 wr_lblk,
   input  logic [PW-1:0]                 wr_pblk,
   input  logic                          wr_new,
   input  logic                          wr_data,
   input  logic [TS_W-1:0]               wr_time,
   input  logic                          md_valid,
   input  logic [SW-1:0]                 md_idx,
   input  logic [LW-1:0]                 q_lblk,
   output logic                          q_pending,
   input  logic [SW-1:0]                 rd_idx,
   output logic                          rd_valid,
   output logic [LW-1:0]                 rd_lblk,
   output logic [PW-1:0]                 rd_pblk,
   output logic                          rd_new,
   output logic [TS_W-1:0]               rd_time,
   output logic                          rd_pending,
   output logic [NUM_SPARE-1:0]          all_valid,
   output logic [NUM_SPARE-1:0]          all_pending,
   output logic [NUM_SPARE-1:0][PW-1:0]  all_pblk,
   output logic [NUM_SPARE-1:0][TS_W-1:0] all_time
);
   import bbr_pkg::*;

   logic                v_q    [NUM_SPARE];
   logic [LW-1:0]       lblk_q [NUM_SPARE];
   logic [PW-1:0]       pblk_q [NUM_SPARE];
   bad_kind_e           kind_q [NUM_SPARE];
   logic [TS_W-1:0]     time_q [NUM_SPARE];
   mig_state_e          mig_q  [NUM_SPARE];

   for (genvar s = 0; s < NUM_SPARE; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q[s]    <= 1'b0;
            lblk_q[s] <= '0;
            pblk_q[s] <= '0;
            kind_q[s] <= BK_FACTORY;
            time_q[s] <= '0;
            mig_q[s]  <= MIG_RETIRED;
         end else if (wr_en && (wr_slot == SW'(s))) begin
            v_q[s]    <= 1'b1;
            lblk_q[s] <= wr_lblk;
            pblk_q[s] <= wr_pblk;
            kind_q[s] <= wr_new ? BK_IN_USE : BK_FACTORY;
            time_q[s] <= wr_time;
            mig_q[s]  <= wr_data ? MIG_PENDING : MIG_RETIRED;
         end else if (md_valid && (md_idx == SW'(s)) && v_q[s]) begin
            mig_q[s]  <= MIG_RETIRED;
         end
      end
      assign all_valid[s]   = v_q[s];
      assign all_pending[s] = v_q[s] && (mig_q[s] == MIG_PENDING);
      assign all_pblk[s]    = pblk_q[s];
      assign all_time[s]    = time_q[s];
   end

   always_comb begin
      q_pending = 1'b0;
      for (int s = 0; s < NUM_SPARE; s++)
         if (v_q[s] && (mig_q[s] == MIG_PENDING) && (lblk_q[s] == q_lblk))
            q_pending = 1'b1;
   end

   assign rd_valid   = v_q[rd_idx];
   assign rd_lblk    = lblk_q[rd_idx];
   assign rd_pblk    = pblk_q[rd_idx];
   assign rd_new     = (kind_q[rd_idx] == BK_IN_USE);
   assign rd_time    = time_q[rd_idx];
   assign rd_pending = v_q[rd_idx] && (mig_q[rd_idx] == MIG_PENDING);
endmodule

// File: rtl/bbr_remap_table.sv
module bbr_remap_table #(
   parameter int NUM_LOG   = 16,
   parameter int NUM_SPARE = 4,
   parameter int TS_W      = 16,
   parameter bit RSP_REG   = 1'b1,
   localparam int LW = $clog2(NUM_LOG),
   localparam int PW = $clog2(NUM_LOG + NUM_SPARE),
   localparam int SW = $clog2(NUM_SPARE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [LW-1:0]   lk_lblk,
   output logic            rsp_valid,
   output logic [PW-1:0]   rsp_pblk,
   output logic            rsp_pending,
   input  logic            mk_valid,
   input  logic [PW-1:0]   mk_pblk,
   input  logic            mk_new,
   input  logic            mk_has_data,
   input  logic            md_valid,
   input  logic [SW-1:0]   md_idx,
   input  logic [SW-1:0]   rec_idx,
   output logic            rec_valid,
   output logic [LW-1:0]   rec_lblk,
   output logic [PW-1:0]   rec_pblk,
   output logic            rec_new,
   output logic [TS_W-1:0] rec_time,
   output logic            rec_pending,
   output logic            spare_exhausted
);
   if (NUM_LOG < 2 || NUM_LOG != (1 << LW)) begin : g_chk_log
      $error("NUM_LOG must be a power of two of at least 2");
   end
   if (NUM_SPARE < 2 || NUM_SPARE != (1 << SW)) begin : g_chk_spare
      $error("NUM_SPARE must be a power of two of at least 2");
   end
   if (TS_W < 1) begin : g_chk_ts
      $error("TS_W must be positive");
   end

   logic [TS_W-1:0]                 ts_q;
   logic                            map_hit;
   logic [LW-1:0]                   hit_lblk;
   logic                            mk_try;
   logic                            grant;
   logic [SW-1:0]                   slot;
   logic [PW-1:0]                   spare_pblk;
   logic [LW-1:0]                   q_lblk;
   logic [NUM_LOG-1:0][PW-1:0]      map_flat;
   logic [NUM_SPARE-1:0]            rv_all;
   logic [NUM_SPARE-1:0]            rp_all;
   logic [NUM_SPARE-1:0][PW-1:0]    rb_all;
   logic [NUM_SPARE-1:0][TS_W-1:0]  rt_all;

   always_ff @(posedge clk) begin
      if (!rst_n) ts_q <= '0;
      else        ts_q <= ts_q + TS_W'(1);
   end

   assign mk_try = mk_valid & map_hit;

   if (RSP_REG) begin : g_rsp_reg
      logic          v_q;
      logic [LW-1:0] l_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            l_q <= '0;
         end else begin
            v_q <= lk_valid;
            if (lk_valid) l_q <= lk_lblk;
         end
      end
      assign rsp_valid = v_q;
      assign q_lblk    = l_q;
   end else begin : g_rsp_comb
      assign rsp_valid = lk_valid;
      assign q_lblk    = lk_lblk;
   end

   bbr_spare_pool #(.NUM_LOG(NUM_LOG), .NUM_SPARE(NUM_SPARE)) u_pool (
      .clk(clk), .rst_n(rst_n), .take(mk_try), .grant(grant),
      .slot(slot), .spare_pblk(spare_pblk), .exhausted(spare_exhausted)
   );

   bbr_map_table #(.NUM_LOG(NUM_LOG), .NUM_SPARE(NUM_SPARE)) u_map (
      .clk(clk), .rst_n(rst_n), .find_pblk(mk_pblk), .hit(map_hit),
      .hit_lblk(hit_lblk), .wr_en(grant), .wr_lblk(hit_lblk),
      .wr_pblk(spare_pblk), .rd_lblk(q_lblk), .rd_pblk(rsp_pblk),
      .map_flat(map_flat)
   );

   bbr_record_file #(.NUM_LOG(NUM_LOG), .NUM_SPARE(NUM_SPARE), .TS_W(TS_W)) u_rec (
      .clk(clk), .rst_n(rst_n), .wr_en(grant), .wr_slot(slot),
      .wr_lblk(hit_lblk), .wr_pblk(mk_pblk), .wr_new(mk_new),
      .wr_data(mk_has_data), .wr_time(ts_q), .md_valid(md_valid),
      .md_idx(md_idx), .q_lblk(q_lblk), .q_pending(rsp_pending),
      .rd_idx(rec_idx), .rd_valid(rec_valid), .rd_lblk(rec_lblk),
      .rd_pblk(rec_pblk), .rd_new(rec_new), .rd_time(rec_time),
      .rd_pending(rec_pending), .all_valid(rv_all), .all_pending(rp_all),
      .all_pblk(rb_all), .all_time(rt_all)
   );
endmodule

// File: rtl/bbr_remap_chk.sv
module bbr_remap_chk #(
   parameter int NUM_LOG   = 16,
   parameter int NUM_SPARE = 4,
   parameter int TS_W      = 16,
   localparam int PW = $clog2(NUM_LOG + NUM_SPARE),
   localparam int SW = $clog2(NUM_SPARE)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           rsp_valid,
   input logic [PW-1:0]                  rsp_pblk,
   input logic                           mk_valid,
   input logic                           mk_try,
   input logic                           md_valid,
   input logic [SW-1:0]                  md_idx,
   input logic                           spare_exhausted,
   input logic [TS_W-1:0]                ts,
   input logic [NUM_LOG-1:0][PW-1:0]     map_flat,
   input logic [NUM_SPARE-1:0]           rv_all,
   input logic [NUM_SPARE-1:0]           rp_all,
   input logic [NUM_SPARE-1:0][PW-1:0]   rb_all,
   input logic [NUM_SPARE-1:0][TS_W-1:0] rt_all
);
   p_rsp_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_pblk < PW'(NUM_LOG + NUM_SPARE)));

   p_exhaust_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      spare_exhausted |=> spare_exhausted);

   p_full_keeps_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mk_try && (&rv_all)) |=> ($stable(map_flat) && $stable(rv_all)));

   p_ignored_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mk_valid && !mk_try) |=> ($stable(map_flat) && $stable(rv_all)
                                 && $stable(spare_exhausted)));

   for (genvar s = 0; s < NUM_SPARE; s++) begin : g_slot
      p_rsp_not_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && rv_all[s]) |-> (rsp_pblk != rb_all[s]));

      p_time_stamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rv_all[s]) |-> (rt_all[s] == $past(ts)));

      p_retire_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rv_all[s] && !rp_all[s]) |=> !rp_all[s]);

      p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rv_all[s] && $fell(rp_all[s])) |-> $past(md_valid && (md_idx == SW'(s))));
   end
endmodule

bind bbr_remap_table bbr_remap_chk #(
   .NUM_LOG(NUM_LOG), .NUM_SPARE(NUM_SPARE), .TS_W(TS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_pblk(rsp_pblk),
   .mk_valid(mk_valid), .mk_try(mk_try), .md_valid(md_valid),
   .md_idx(md_idx), .spare_exhausted(spare_exhausted), .ts(ts_q),
   .map_flat(map_flat), .rv_all(rv_all), .rp_all(rp_all),
   .rb_all(rb_all), .rt_all(rt_all)
);

// File: tb/tb_bbr_remap_table.sv
module tb_bbr_remap_table;
   localparam int NL = 16;
   localparam int NS = 4;
   localparam int TW = 16;
   localparam int LW = $clog2(NL);
   localparam int PW = $clog2(NL + NS);
   localparam int SW = $clog2(NS);

   localparam logic [1:0] OP_LK = 2'd0, OP_MK = 2'd1, OP_MD = 2'd2;
   // {op, arg, flags{new,data}, expected, expected pending}
   localparam int NV = 19;
   localparam logic [20:0] VEC [NV] = '{
      {OP_LK, 8'd3,  2'b00, 8'd3,   1'b0},
      {OP_MK, 8'd3,  2'b11, 8'd0,   1'b0},
      {OP_LK, 8'd3,  2'b00, 8'd16,  1'b1},
      {OP_LK, 8'd4,  2'b00, 8'd4,   1'b0},
      {OP_MD, 8'd0,  2'b00, 8'd0,   1'b0},
      {OP_LK, 8'd3,  2'b00, 8'd16,  1'b0},
      {OP_MK, 8'd7,  2'b00, 8'd1,   1'b0},
      {OP_LK, 8'd7,  2'b00, 8'd17,  1'b0},
      {OP_MK, 8'd3,  2'b10, 8'hFF,  1'b0},
      {OP_LK, 8'd3,  2'b00, 8'd16,  1'b0},
      {OP_MK, 8'd18, 2'b10, 8'hFF,  1'b0},
      {OP_MK, 8'd16, 2'b11, 8'd2,   1'b0},
      {OP_LK, 8'd3,  2'b00, 8'd18,  1'b1},
      {OP_MD, 8'd1,  2'b00, 8'd0,   1'b0},
      {OP_MK, 8'd9,  2'b00, 8'd3,   1'b0},
      {OP_LK, 8'd9,  2'b00, 8'd19,  1'b0},
      {OP_MK, 8'd5,  2'b10, 8'hFE,  1'b0},
      {OP_LK, 8'd5,  2'b00, 8'd5,   1'b0},
      {OP_LK, 8'd3,  2'b00, 8'd18,  1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_valid = 1'b0, mk_valid = 1'b0, md_valid = 1'b0;
   logic mk_new = 1'b0, mk_has_data = 1'b0;
   logic [LW-1:0] lk_lblk = '0;
   logic [PW-1:0] mk_pblk = '0;
   logic [SW-1:0] md_idx = '0, rec_idx = '0;
   logic rsp_valid, rsp_pending, rec_valid, rec_new, rec_pending, spare_exhausted;
   logic [PW-1:0] rsp_pblk, rec_pblk;
   logic [LW-1:0] rec_lblk;
   logic [TW-1:0] rec_time;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;
   int exp_time [NS];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   bbr_remap_table #(.NUM_LOG(NL), .NUM_SPARE(NS), .TS_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_lblk(lk_lblk),
      .rsp_valid(rsp_valid), .rsp_pblk(rsp_pblk), .rsp_pending(rsp_pending),
      .mk_valid(mk_valid), .mk_pblk(mk_pblk), .mk_new(mk_new),
      .mk_has_data(mk_has_data), .md_valid(md_valid), .md_idx(md_idx),
      .rec_idx(rec_idx), .rec_valid(rec_valid), .rec_lblk(rec_lblk),
      .rec_pblk(rec_pblk), .rec_new(rec_new), .rec_time(rec_time),
      .rec_pending(rec_pending), .spare_exhausted(spare_exhausted)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic lookup(input int l, input int ep, input bit epend, input string req);
      lk_valid = 1'b1; lk_lblk = LW'(l);
      @(negedge clk);
      lk_valid = 1'b0;
      chk({req, " rsp_valid"}, rsp_valid, 1);
      chk({req, " rsp_pblk"}, rsp_pblk, ep);
      chk({req, " rsp_pending"}, rsp_pending, epend);
   endtask

   task automatic mark(input int p, input bit nw, input bit dat);
      mk_valid = 1'b1; mk_pblk = PW'(p); mk_new = nw; mk_has_data = dat;
      @(negedge clk);
      mk_valid = 1'b0;
   endtask

   task automatic mig(input int idx);
      md_valid = 1'b1; md_idx = SW'(idx);
      @(negedge clk);
      md_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: identity map, empty records, flag low
      chk("R1 exhausted", spare_exhausted, 0);
      for (int s = 0; s < NS; s++) begin
         rec_idx = SW'(s); #1;
         chk("R1 rec_valid", rec_valid, 0);
      end
      for (int l = 0; l < NL; l++) lookup(l, l, 1'b0, "R1");

      // Vector walk: R2 R4 R5 R6 R7 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         logic [7:0] a, e;
         logic [1:0] f;
         logic ep;
         {op, a, f, e, ep} = VEC[i];
         case (op)
            OP_LK: lookup(a, e, ep, "R6 lookup");
            OP_MK: begin
               if (e < NS) begin
                  rec_idx = SW'(e);
                  exp_time[e] = cyc;
               end
               mark(a, f[1], f[0]);
               if (e < NS) begin
                  chk("R2 rec_valid", rec_valid, 1);
                  chk("R10 rec_pblk", rec_pblk, a);
               end else if (e == 8'hFF) begin
                  chk("R8 exhausted unchanged", spare_exhausted, 0);
               end else begin
                  chk("R7 exhausted set", spare_exhausted, 1);
               end
            end
            default: mig(a);
         endcase
      end

      // R3: record contents
      begin
         int el [NS] = '{3, 7, 3, 9};
         int eb [NS] = '{3, 7, 16, 9};
         int en [NS] = '{1, 0, 1, 0};
         int epd [NS] = '{0, 0, 1, 0};
         for (int s = 0; s < NS; s++) begin
            rec_idx = SW'(s); #1;
            chk("R3 lblk", rec_lblk, el[s]);
            chk("R3 pblk", rec_pblk, eb[s]);
            chk("R3 type", rec_new, en[s]);
            chk("R3 time", rec_time, exp_time[s]);
            chk("R4 R5 R9 pending", rec_pending, epd[s]);
         end
      end
      // R7: still sticky after further marks, mapping intact
      mark(4, 1'b1, 1'b0);
      chk("R7 sticky", spare_exhausted, 1);
      lookup(4, 4, 1'b0, "R7 map kept");
      // R4: finish migration of slot 2
      mig(2);
      rec_idx = SW'(2); #1;
      chk("R4 retired", rec_pending, 0);
      lookup(3, 18, 1'b0, "R4 lookup");
      mig(2);
      chk("R4 stays retired", rec_pending, 0);

      // R9: migrate-done on an empty slot does not pre-clear a later record
      do_reset();
      chk("R1 exhausted after reset", spare_exhausted, 0);
      mig(0);
      rec_idx = '0; #1;
      chk("R9 empty slot", rec_valid, 0);
      mark(2, 1'b0, 1'b1);
      chk("R9 new record pending", rec_pending, 1);
      chk("R3 factory type", rec_new, 0);
      lookup(2, 16, 1'b1, "R9 lookup");
      finish_run();
   end
endmodule